// File: doc/BRIEF.md
# Mode-Mapped Accumulator Tile Store

This block holds the 32-bit accumulator words of one compute unit. It has 128 lanes, and each lane holds a parameterised number of columns. The physical limit is 512 columns; the default is 16. A producer presents a logical element (row, column N) together with a partial sum. A two-bit mode input and an alignment bit select how that element is placed on a lane and a column. The write port then adds the partial sum to the stored word, or overwrites the word when the element is marked as the first accumulation step. Arithmetic is plain 32-bit integer addition that wraps.

The placement modes are as follows, with the mode input value in brackets:

- Full tile, one unit (0): rows map straight to lanes.
- Short tile, one unit (1): 64 rows are spread over the lanes in strided runs of 16. The alignment bit chooses between two complementary sets of lanes, so two independent short tiles can share the store without overlap.
- Tall tile, two units (2): 256 rows are split by the top row bit across the two units.
- Packed tile, two units (3): 128 rows are split across the two units. Within a unit, the upper half of N is folded onto lanes 64..127.

In the two-unit modes the computed unit index is shown on an output. Only elements that belong to this unit, set by a parameter, are stored.

An epilogue reads the store through a separate read port. It addresses one lane and one column, and the data arrives one cycle later. The epilogue should wait for the done flag before it treats the data as final. A write that falls outside the tile is dropped and raises a sticky error flag.

Top module: `acc_tile_store`

## Requirements
- R1: In mode 0, logical row m (0..127) maps to lane m and logical column n maps to column n; map_unit is 0.
- R2: In mode 1, row m (0..63) maps to lane 32*(m/16) + m%16 when align is 0, and to that lane plus 16 when align is 1. The column is n.
- R3: In mode 2, map_unit is m/128 and the lane is m%128. The column is n.
- R4: In mode 3, map_unit is m/64 and r = m%64. If n < cfg_n/2 the element goes to lane r, column n. Otherwise it goes to lane 64+r, column n - cfg_n/2.
- R5: An accepted write with wr_first high stores wr_data. An accepted write with wr_first low stores the old word plus wr_data, modulo 2^32.
- R6: A read request is answered in the next cycle: rd_valid is high and rd_data holds the word at (rd_lane, rd_col).
- R7: A read of the same address that an accepted write targets in the same cycle returns the value that write stores.
- R8: A write is invalid if n >= cfg_n, or if m >= 64 in mode 1, or if m >= 128 in modes 0 and 3. An invalid write leaves storage unchanged and sets err, which stays high until reset.
- R9: A valid write whose map_unit differs from the UNIT_ID parameter (default 0) leaves storage unchanged and does not set err.
- R10: One cycle after an accepted write with wr_last high, done is 1. An accepted write without wr_last clears done one cycle later. Reset clears err, done and rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Placement mode 0..3 |
| align | input | 1 | Lane-set select for mode 1 |
| cfg_n | input | NW | Configured logical N |
| wr_en | input | 1 | Write request |
| wr_first | input | 1 | Overwrite instead of accumulate |
| wr_last | input | 1 | Final write of the accumulation |
| wr_row | input | 8 | Logical row m |
| wr_n | input | NW | Logical column n |
| wr_data | input | DW | Partial sum |
| map_unit | output | 1 | Unit index of the current write element |
| map_lane | output | 7 | Mapped lane |
| map_col | output | NW | Mapped column |
| map_bad | output | 1 | Current write element is outside the tile |
| rd_en | input | 1 | Read request |
| rd_lane | input | 7 | Read lane |
| rd_col | input | CW | Read column |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DW | Read word |
| done | output | 1 | Accumulation complete |
| err | output | 1 | Sticky out-of-tile error |

## Verification
The embedded properties check the following on every cycle:

- Read latency.
- The stickiness of err, and that every out-of-tile write raises it.
- That done follows an accepted final write.
- That mode 1 places a row only in the lane set picked by align.
- That the bypass path returns the value just written.

The bench scenarios show what the properties cannot:

- The exact lane and column arithmetic of each mode.
- Overwrite versus accumulation, and the wrap of the integer sum.
- That dropped and foreign-unit writes leave stored words untouched.

// File: rtl/acc_tile_store.sv
module acc_tile_store #(
  parameter int COLS = 16,
  parameter int DW = 32,
  parameter bit UNIT_ID = 1'b0,
  localparam int CW = $clog2(COLS),
  localparam int NW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          align,
  input  logic [NW-1:0] cfg_n,
  input  logic          wr_en,
  input  logic          wr_first,
  input  logic          wr_last,
  input  logic [7:0]    wr_row,
  input  logic [NW-1:0] wr_n,
  input  logic [DW-1:0] wr_data,
  output logic          map_unit,
  output logic [6:0]    map_lane,
  output logic [NW-1:0] map_col,
  output logic          map_bad,
  input  logic          rd_en,
  input  logic [6:0]    rd_lane,
  input  logic [CW-1:0] rd_col,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done,
  output logic          err
);
  localparam int LANES = 128;
  localparam int AW = 7 + CW;

  logic [DW-1:0] mem [LANES*COLS];
  logic [NW-1:0] half_n;
  logic          upper, row_oob, accept;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] sum;

  assign half_n = cfg_n >> 1;
  assign upper  = wr_n >= half_n;

  always_comb begin
    map_unit = 1'b0;
    map_lane = wr_row[6:0];
    map_col  = wr_n;
    row_oob  = 1'b0;
    case (mode)
      2'd0: row_oob = wr_row[7];
      2'd1: begin
        map_lane = {wr_row[5:4], align, wr_row[3:0]};
        row_oob  = |wr_row[7:6];
      end
      2'd2: map_unit = wr_row[7];
      default: begin
        map_unit = wr_row[6];
        map_lane = {upper, wr_row[5:0]};
        map_col  = upper ? wr_n - half_n : wr_n;
        row_oob  = wr_row[7];
      end
    endcase
  end

  assign map_bad = row_oob || (wr_n >= cfg_n);
  assign accept  = wr_en && !map_bad && (map_unit == UNIT_ID);
  assign waddr   = {map_lane, map_col[CW-1:0]};
  assign raddr   = {rd_lane, rd_col};
  assign sum     = wr_first ? wr_data : mem[waddr] + wr_data;

  always_ff @(posedge clk) begin
    if (accept) mem[waddr] <= sum;
    if (rd_en) rd_data <= (accept && waddr == raddr) ? sum : mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (accept) done <= wr_last;
      if (wr_en && map_bad) err <= 1'b1;
    end
  end

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rd_valid); // R6
  AST_BYPASS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && accept && waddr == raddr) |=> rd_data == $past(sum)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R8
  AST_BAD_RAISES: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && map_bad) |=> err); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_last && !map_bad && map_unit == UNIT_ID) |=> done); // R10
  AST_ALIGN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'd1 && !map_bad) |-> map_lane[4] == align); // R2
  AST_PACKED_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode == 2'd3 && !map_bad) |-> map_col < cfg_n); // R4
endmodule

// File: tb/acc_tile_store_test.sv
module acc_tile_store_test;
  localparam int PERIOD = 10;
  localparam int COLS = 16;
  localparam int CW = $clog2(COLS);
  localparam int NW = CW + 1;

  logic clk = 0, rst_n = 0;
  logic [1:0] mode = 0;
  logic align = 0;
  logic [NW-1:0] cfg_n = NW'(COLS);
  logic wr_en = 0, wr_first = 0, wr_last = 0;
  logic [7:0] wr_row = 0;
  logic [NW-1:0] wr_n = 0;
  logic [31:0] wr_data = 0;
  logic map_unit, map_bad, rd_valid, done, err;
  logic [6:0] map_lane;
  logic [NW-1:0] map_col;
  logic rd_en = 0;
  logic [6:0] rd_lane = 0;
  logic [CW-1:0] rd_col = 0;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;
  logic [31:0] bm [128][COLS];
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  acc_tile_store #(.COLS(COLS)) uut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_map(input int md, input int al, input int m, input int n, input int cn,
                           output int u, output int ln, output int cl, output int bad);
    u = 0; ln = m; cl = n; bad = (n >= cn);
    case (md)
      0: bad = bad | (m >= 128);
      1: begin ln = (m / 16) * 32 + al * 16 + m % 16; bad = bad | (m >= 64); end
      2: begin u = m / 128; ln = m % 128; end
      default: begin
        u = m / 64; bad = bad | (m >= 128);
        if (n >= cn / 2) begin ln = 64 + m % 64; cl = n - cn / 2; end
        else ln = m % 64;
      end
    endcase
  endtask

  task automatic drive_wr(input string req, input int md, input int al, input int m, input int n,
                          input int d, input bit first, input bit last, input bit rd_same);
    int u, ln, cl, bad;
    @(negedge clk);
    mode = 2'(md); align = al[0]; wr_row = 8'(m); wr_n = NW'(n); wr_data = d;
    wr_first = first; wr_last = last; wr_en = 1; rd_en = 0;
    model_map(md, al, m, n, int'(cfg_n), u, ln, cl, bad);
    #1;
    chk({req, " map_bad"}, map_bad, bad);
    if (!bad) begin
      chk({req, " unit"}, map_unit, u);
      chk({req, " lane"}, map_lane, ln);
      chk({req, " col"}, map_col, cl);
      if (u == 0) bm[ln][cl] = first ? 32'(d) : bm[ln][cl] + 32'(d);
    end
    if (rd_same && !bad) begin
      rd_en = 1; rd_lane = 7'(ln); rd_col = CW'(cl);
      exp_q.push_back(bm[ln][cl]); tag_q.push_back("R7");
    end
  endtask

  task automatic drive_rd(input int ln, input int cl, input string req);
    @(negedge clk);
    wr_en = 0; rd_en = 1; rd_lane = 7'(ln); rd_col = CW'(cl);
    exp_q.push_back(bm[ln][cl]); tag_q.push_back(req);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); wr_en = 0; rd_en = 0; end
  endtask

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R6 unexpected rd_valid", 1, 0);
      else chk({tag_q.pop_front(), " rd_data"}, rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10 reset err", err, 0);
    chk("R10 reset done", done, 0);
    chk("R6 reset rd_valid", rd_valid, 0);

    drive_wr("R1", 0, 0, 5, 3, 10, 1, 0, 0);
    drive_wr("R5", 0, 0, 5, 3, 7, 0, 0, 0);
    drive_rd(5, 3, "R5 accumulate");
    drive_wr("R5", 0, 0, 127, 15, 32'hFFFF_FFF0, 1, 0, 0);
    drive_wr("R5", 0, 0, 127, 15, 32'h20, 0, 0, 0);
    drive_rd(127, 15, "R5 wrap");
    drive_wr("R5", 0, 0, 5, 3, 55, 1, 0, 0);
    drive_rd(5, 3, "R5 overwrite");
    idle(1);
    chk("R6 rd_valid", rd_valid, 1);

    drive_wr("R2", 1, 0, 20, 2, 11, 1, 0, 0);
    drive_wr("R2", 1, 1, 20, 2, 22, 1, 0, 0);
    drive_wr("R2", 1, 1, 63, 9, 33, 1, 0, 0);
    drive_rd(36, 2, "R2 align0");
    drive_rd(52, 2, "R2 align1");
    drive_rd(127, 9, "R2 last run");

    drive_wr("R1", 0, 0, 72, 4, 99, 1, 0, 0);
    drive_wr("R3", 2, 0, 200, 4, 5, 1, 0, 0);
    drive_wr("R3", 2, 0, 72, 4, 1, 0, 0, 0);
    drive_rd(72, 4, "R9 R3 foreign dropped");
    idle(1);
    chk("R9 no err", err, 0);

    drive_wr("R4", 3, 0, 10, 12, 40, 1, 0, 0);
    drive_wr("R4", 3, 0, 10, 3, 41, 1, 0, 0);
    drive_wr("R4", 3, 0, 70, 12, 42, 1, 0, 0);
    drive_rd(74, 4, "R4 upper half");
    drive_rd(10, 3, "R4 lower half");

    drive_wr("R7", 0, 0, 74, 4, 8, 0, 0, 1);
    drive_wr("R7", 0, 0, 30, 6, 123, 1, 0, 1);

    drive_wr("R10", 0, 0, 1, 1, 1, 1, 1, 0);
    idle(1);
    chk("R10 done set", done, 1);
    drive_wr("R10", 0, 0, 1, 1, 1, 0, 0, 0);
    idle(1);
    chk("R10 done cleared", done, 0);
    chk("R8 err clear before", err, 0);

    drive_wr("R8", 0, 0, 30, 16, 500, 1, 1, 0);
    idle(1);
    chk("R8 err set", err, 1);
    chk("R8 dropped no done", done, 0);
    drive_wr("R8", 1, 0, 64, 0, 500, 1, 0, 0);
    drive_rd(30, 6, "R8 storage unchanged");
    drive_wr("R8", 0, 0, 30, 6, 1, 0, 0, 0);
    idle(2);
    chk("R8 err sticky", err, 1);
    drive_rd(30, 6, "R8 after valid write");
    idle(3);
    chk("R6 queue drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule